// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steers a multicycle processor datapath from a small internal microprogram. A microaddress register selects one word of an on-chip constant control store. Each word stands for one control state and describes that state completely. The datapath strobes and multiplexer selects are wired straight from the fields of the current word, so every output is a function of the microaddress alone.

A two-bit sequencing field in each word picks the next microaddress. The four choices are: back to the fetch word at address 0, a jump through the first opcode-indexed table, a jump through the second opcode-indexed table, or the next address in line. The first table is consulted at the end of instruction decode and sends each instruction class to its first execution word. The second table is consulted after the memory address step and separates loads from stores.

The surrounding datapath supplies the 6-bit opcode from its instruction register and receives the controls. No other inputs exist.

Top module: `ucode_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, the block presents the fetch controls: mem_rd=1, ir_wr=1, pc_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src=00, and every other strobe 0. Lowering rst_n in the middle of an instruction returns the block to fetch at once.
- R2: The sequencing code 3 advances the microaddress by one. As a result, fetch is followed by decode, the load memory read is followed by load writeback, and the register-op execute is followed by register-op completion.
- R3: In decode, the next state depends on the opcode. Opcodes 6'h23 and 6'h2B go to address compute, 6'h00 goes to register-op execute, 6'h04 goes to branch, and 6'h02 goes to jump.
- R4: In address compute, the next state depends on the opcode present in that cycle. Opcode 6'h23 goes to the load memory read and 6'h2B goes to the store write.
- R5: Load writeback, store write, register-op completion, branch and jump are each followed by fetch.
- R6: An opcode with no entry in the table used in that cycle sends the sequencer to fetch. This applies in decode and in address compute.
- R7: Each instruction class produces its control sequence cycle for cycle. A load takes 5 cycles, a store 4, a register op 4, a branch 3 and a jump 3. The non-fetch states are:
  - decode: alu_b_sel=11.
  - address compute: alu_a_sel=1, alu_b_sel=10.
  - load read: mem_rd=1, addr_sel=1.
  - load writeback: reg_wr=1, mem_to_reg=1, reg_dst=0.
  - store write: mem_wr=1, addr_sel=1.
  - register-op execute: alu_a_sel=1, alu_b_sel=00, alu_op=10.
  - register-op completion: reg_wr=1, reg_dst=1.
  - branch: alu_a_sel=1, alu_op=01, pc_wr_cond=1, pc_src=01.
  - jump: pc_wr=1, pc_src=10.
  - Every field not listed is 0.
- R8: The opcode has no effect on the outputs or on the next state outside decode and address compute.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to microaddress 0 |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the ALU result is zero |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU output register |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALU output, 1 memory data |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register field: 0 rt, 1 rd |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU first operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 extended immediate, 11 extended shifted immediate |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU output register, 10 jump target |

## Verification
An opcode change can fall in the same cycle as a table lookup, or in a cycle where the opcode should be ignored. The bench swaps the opcode inside address compute, which must redirect the second lookup. It also swaps the opcode inside the load read and the fetch cycles, which must change nothing. The state that follows is judged from the control pattern. A reset edge can also coincide with an advance that sequencing would make. This is provoked by dropping rst_n mid-instruction, and the fetch pattern must appear before the next clock edge.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UADDR_W = 4;
  localparam int OPC_W   = 6;
  localparam int UDEPTH  = 10;
  localparam int USLOTS  = 1 << UADDR_W;

  typedef logic [UADDR_W-1:0] uaddr_t;
  typedef logic [OPC_W-1:0]   opc_t;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_e;

  localparam opc_t OPC_REG   = 6'h00;
  localparam opc_t OPC_JUMP  = 6'h02;
  localparam opc_t OPC_BEQ   = 6'h04;
  localparam opc_t OPC_LOAD  = 6'h23;
  localparam opc_t OPC_STORE = 6'h2B;

  // microaddresses; order matters where SEQ_NEXT links neighbours
  localparam uaddr_t UA_FETCH  = 4'd0;
  localparam uaddr_t UA_DECODE = 4'd1;
  localparam uaddr_t UA_MADDR  = 4'd2;
  localparam uaddr_t UA_LDRD   = 4'd3;
  localparam uaddr_t UA_LDWB   = 4'd4;
  localparam uaddr_t UA_STWR   = 4'd5;
  localparam uaddr_t UA_REXE   = 4'd6;
  localparam uaddr_t UA_RDONE  = 4'd7;
  localparam uaddr_t UA_BRANCH = 4'd8;
  localparam uaddr_t UA_JUMP   = 4'd9;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;
  localparam logic [1:0] OPB_REG  = 2'b00;
  localparam logic [1:0] OPB_FOUR = 2'b01;
  localparam logic [1:0] OPB_IMM  = 2'b10;
  localparam logic [1:0] OPB_IMMS = 2'b11;
  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HOLD = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       mem_to_reg;
    logic       reg_wr;
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] pc_src;
  } ctrl_t;

  typedef struct packed {
    ctrl_t ctrl;
    seq_e  seq;
  } uword_t;

  // Control store contents; unused slots return to fetch with all strobes low.
  function automatic uword_t ucode_word(input int unsigned a);
    uword_t w;
    w     = '0;
    w.seq = SEQ_FETCH;
    case (a)
      0: begin
        w.ctrl.mem_rd = 1'b1; w.ctrl.ir_wr = 1'b1; w.ctrl.pc_wr = 1'b1;
        w.ctrl.alu_b_sel = OPB_FOUR; w.ctrl.alu_op = ALU_ADD;
        w.ctrl.pc_src = PCS_ALU; w.seq = SEQ_NEXT;
      end
      1: begin w.ctrl.alu_b_sel = OPB_IMMS; w.seq = SEQ_DISP1; end
      2: begin w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_b_sel = OPB_IMM; w.seq = SEQ_DISP2; end
      3: begin w.ctrl.mem_rd = 1'b1; w.ctrl.addr_sel = 1'b1; w.seq = SEQ_NEXT; end
      4: begin w.ctrl.reg_wr = 1'b1; w.ctrl.mem_to_reg = 1'b1; end
      5: begin w.ctrl.mem_wr = 1'b1; w.ctrl.addr_sel = 1'b1; end
      6: begin
        w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_b_sel = OPB_REG;
        w.ctrl.alu_op = ALU_FUNC; w.seq = SEQ_NEXT;
      end
      7: begin w.ctrl.reg_wr = 1'b1; w.ctrl.reg_dst = 1'b1; end
      8: begin
        w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_op = ALU_SUB;
        w.ctrl.pc_wr_cond = 1'b1; w.ctrl.pc_src = PCS_HOLD;
      end
      9: begin w.ctrl.pc_wr = 1'b1; w.ctrl.pc_src = PCS_JMP; end
      default: ;
    endcase
    return w;
  endfunction

  function automatic uaddr_t class_entry(input opc_t op);
    case (op)
      OPC_LOAD, OPC_STORE: return UA_MADDR;
      OPC_REG:             return UA_REXE;
      OPC_BEQ:             return UA_BRANCH;
      OPC_JUMP:            return UA_JUMP;
      default:             return UA_FETCH;
    endcase
  endfunction

  function automatic uaddr_t mem_entry(input opc_t op);
    case (op)
      OPC_LOAD:  return UA_LDRD;
      OPC_STORE: return UA_STWR;
      default:   return UA_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
(
  input  uaddr_t addr,
  output uword_t word
);
  uword_t words [USLOTS];

  for (genvar i = 0; i < USLOTS; i++) begin : g_word
    assign words[i] = ucode_word(i);
  end

  assign word = words[addr];
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
(
  input  opc_t   opcode,
  output uaddr_t disp1_addr,
  output uaddr_t disp2_addr
);
  assign disp1_addr = class_entry(opcode);
  assign disp2_addr = mem_entry(opcode);
endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
(
  input  seq_e   seq_sel,
  input  uaddr_t upc,
  input  uaddr_t disp1_addr,
  input  uaddr_t disp2_addr,
  output uaddr_t upc_next
);
  always_comb begin
    case (seq_sel)
      SEQ_DISP1: upc_next = disp1_addr;
      SEQ_DISP2: upc_next = disp2_addr;
      SEQ_NEXT:  upc_next = uaddr_t'(upc + 1'b1);
      default:   upc_next = UA_FETCH;
    endcase
  end
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_wr,
  output logic             mem_to_reg,
  output logic             reg_wr,
  output logic             reg_dst,
  output logic [1:0]       alu_op,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       pc_src
);
  uaddr_t upc;
  uaddr_t upc_next;
  uaddr_t disp1_addr;
  uaddr_t disp2_addr;
  uword_t uword;
  seq_e   seq_sel;

  ucode_rom u_rom (
    .addr (upc),
    .word (uword)
  );

  ucode_dispatch u_disp (
    .opcode     (opcode),
    .disp1_addr (disp1_addr),
    .disp2_addr (disp2_addr)
  );

  assign seq_sel = uword.seq;

  ucode_next u_next (
    .seq_sel    (seq_sel),
    .upc        (upc),
    .disp1_addr (disp1_addr),
    .disp2_addr (disp2_addr),
    .upc_next   (upc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= UA_FETCH;
    else        upc <= upc_next;
  end

  assign pc_wr      = uword.ctrl.pc_wr;
  assign pc_wr_cond = uword.ctrl.pc_wr_cond;
  assign mem_rd     = uword.ctrl.mem_rd;
  assign mem_wr     = uword.ctrl.mem_wr;
  assign addr_sel   = uword.ctrl.addr_sel;
  assign ir_wr      = uword.ctrl.ir_wr;
  assign mem_to_reg = uword.ctrl.mem_to_reg;
  assign reg_wr     = uword.ctrl.reg_wr;
  assign reg_dst    = uword.ctrl.reg_dst;
  assign alu_op     = uword.ctrl.alu_op;
  assign alu_a_sel  = uword.ctrl.alu_a_sel;
  assign alu_b_sel  = uword.ctrl.alu_b_sel;
  assign pc_src     = uword.ctrl.pc_src;
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk
  import ucode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input uaddr_t           upc,
  input logic [1:0]       seq_sel,
  input logic             mem_rd,
  input logic             mem_wr
);
  logic op_has_class;
  assign op_has_class = (opcode == 6'h23) || (opcode == 6'h2B) || (opcode == 6'h00) ||
                        (opcode == 6'h04) || (opcode == 6'h02);

  AST_RESET_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (upc == 4'd0)); // R1
  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd0) |=> (upc == 4'd1)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == 2'd3) |=> (upc == uaddr_t'($past(upc) + 1'b1))); // R2
  AST_REG_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd1 && opcode == 6'h00) |=> (upc == 4'd6)); // R3
  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd2 && opcode == 6'h2B) |=> (upc == 4'd5)); // R4
  AST_TERMINAL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == 2'd0) |=> (upc == 4'd0)); // R5
  AST_UNMAPPED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd1 && !op_has_class) |=> (upc == 4'd0)); // R6
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (upc < 4'(UDEPTH))); // R7
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
endmodule

bind ucode_ctrl ucode_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opcode  (opcode),
  .upc     (upc),
  .seq_sel (seq_sel),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr)
);

// File: tb/ucode_ctrl_bench.sv
module ucode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h23;
  logic       pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr;
  logic       mem_to_reg, reg_wr, reg_dst, alu_a_sel;
  logic [1:0] alu_op, alu_b_sel, pc_src;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  ucode_ctrl u_ucode_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_sel(addr_sel), .ir_wr(ir_wr), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
    .reg_dst(reg_dst), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .pc_src(pc_src)
  );

  // packing: pc_wr,pc_wr_cond,mem_rd,mem_wr,addr_sel,ir_wr,mem_to_reg,reg_wr,reg_dst,alu_op,alu_a,alu_b,pc_src
  localparam logic [15:0] X_FET = {1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,2'b01,2'b00};
  localparam logic [15:0] X_DEC = {9'b0,2'b00,1'b0,2'b11,2'b00};
  localparam logic [15:0] X_MAD = {9'b0,2'b00,1'b1,2'b10,2'b00};
  localparam logic [15:0] X_LRD = {2'b00,1'b1,1'b0,1'b1,4'b0,2'b00,1'b0,2'b00,2'b00};
  localparam logic [15:0] X_LWB = {6'b0,1'b1,1'b1,1'b0,2'b00,1'b0,2'b00,2'b00};
  localparam logic [15:0] X_STW = {3'b000,1'b1,1'b1,4'b0,2'b00,1'b0,2'b00,2'b00};
  localparam logic [15:0] X_REX = {9'b0,2'b10,1'b1,2'b00,2'b00};
  localparam logic [15:0] X_RDN = {7'b0,1'b1,1'b1,2'b00,1'b0,2'b00,2'b00};
  localparam logic [15:0] X_BRA = {1'b0,1'b1,7'b0,2'b01,1'b1,2'b00,2'b01};
  localparam logic [15:0] X_JMP = {1'b1,8'b0,2'b00,1'b0,2'b00,2'b10};

  localparam int NVEC = 22;
  // {opcode, expected controls}; covers R2, R3, R4, R5, R6 transitions inside R7 sequences
  localparam logic [21:0] VEC [NVEC] = '{
    {6'h23, X_FET}, {6'h23, X_DEC}, {6'h23, X_MAD}, {6'h23, X_LRD}, {6'h23, X_LWB},
    {6'h2B, X_FET}, {6'h2B, X_DEC}, {6'h2B, X_MAD}, {6'h2B, X_STW},
    {6'h00, X_FET}, {6'h00, X_DEC}, {6'h00, X_REX}, {6'h00, X_RDN},
    {6'h04, X_FET}, {6'h04, X_DEC}, {6'h04, X_BRA},
    {6'h02, X_FET}, {6'h02, X_DEC}, {6'h02, X_JMP},
    {6'h3F, X_FET}, {6'h3F, X_DEC},
    {6'h23, X_FET}
  };

  function automatic logic [15:0] observed();
    return {pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr, mem_to_reg, reg_wr,
            reg_dst, alu_op, alu_a_sel, alu_b_sel, pc_src};
  endfunction

  task automatic check(input logic [15:0] exp, input string tag);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s: controls got %h expected %h", tag, observed(), exp);
    end
  endtask

  // called at a falling edge: drive opcode, check the current state, move one cycle on
  task automatic step(input logic [5:0] op, input logic [15:0] exp, input string tag);
    opcode = op;
    #1;
    check(exp, tag);
    @(negedge clk);
  endtask

  task automatic restart();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(X_FET, "R1 held in reset");
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21:16], VEC[i][15:0], "R7 table sequence");
    end

    // R1: reset lowered during register-op execute forces fetch at once
    restart();
    step(6'h00, X_FET, "R1 fetch before abort");
    step(6'h00, X_DEC, "R1 decode before abort");
    opcode = 6'h00;
    #1 check(X_REX, "R1 execute before abort");
    rst_n = 1'b0;
    #1 check(X_FET, "R1 async return to fetch");
    @(negedge clk);
    rst_n = 1'b1;

    // R8: opcode in fetch is ignored, decode uses the value present then (R3)
    step(6'h3F, X_FET, "R8 fetch with unmapped opcode");
    step(6'h02, X_DEC, "R8 decode after ignored opcode");
    step(6'h02, X_JMP, "R3 jump entry");
    // R8: opcode swap during load read does not change the path
    step(6'h23, X_FET, "R8 load fetch");
    step(6'h23, X_DEC, "R8 load decode");
    step(6'h23, X_MAD, "R8 load address");
    step(6'h04, X_LRD, "R8 load read with swapped opcode");
    step(6'h04, X_LWB, "R8 writeback with swapped opcode");
    step(6'h04, X_FET, "R5 fetch after writeback");

    // R6: second table with no entry for the opcode returns to fetch
    step(6'h23, X_DEC, "R6 decode as load");
    step(6'h00, X_MAD, "R6 address with register opcode");
    step(6'h23, X_FET, "R6 unmapped second lookup");
    // R4: second lookup follows the opcode of the address cycle
    step(6'h23, X_DEC, "R4 decode as load");
    step(6'h2B, X_MAD, "R4 address with store opcode");
    step(6'h2B, X_STW, "R4 store selected late");
    step(6'h2B, X_FET, "R5 fetch after store");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run got no end expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule